// File: doc/BRIEF.md
# Bit-Configurable Microcontroller I/O Port

This block is an eight-bit peripheral port that sits on the address/data bus of a microcontroller, where the address and data share the same lines. Each pin is configured on its own. A pin can work as a general-purpose input or output, driven by a direction bit and an output-latch bit that software writes. A pin can also carry one low-order address bit. That bit comes from an internal latch, which captures the shared address/data byte when the address strobe ends.

A small synchronous register interface sets up the port and reads it back. The interface has a chip select, a write strobe, a read strobe, a two-bit offset and a data byte. Software can read the direction bits, the output-latch bits and the live pin levels as separate registers. The pin levels pass through a two-flop synchronizer before they reach the read path.

Each pin driven from its output latch can be set to push-pull or open-drain. The block does not contain real tri-state pads. Each pin is presented as a pair of signals, output-enable and output-value, and the pad ring builds the real pad from them.

Top module: `cfg_io_port`

## Requirements
- R1: After reset, the direction, output-latch, address-mode and open-drain registers are all 0. `pad_oe_o` is 0 on every pin and `bus_rdata_o` is 0.
- R2: A write happens when `bus_cs_i` and `bus_we_i` are both high at a clock edge. Offset 0 writes the direction register, 1 the output latch, 2 the address-mode select and 3 the open-drain select. A write strobe while `bus_cs_i` is low changes no register.
- R3: A pin whose address-mode bit is 0 and whose direction bit is 0 is an input: `pad_oe_o` is 0 and `pad_out_o` is 0.
- R4: A pin with address-mode 0, direction 1 and open-drain 0 drives push-pull: `pad_oe_o` is 1 and `pad_out_o` equals its output-latch bit.
- R5: A pin with address-mode 0, direction 1 and open-drain 1 is open-drain: `pad_oe_o` is the inverse of its output-latch bit and `pad_out_o` is 0, so the pin only ever pulls low.
- R6: A pin whose address-mode bit is 1 drives push-pull with `pad_oe_o` = 1 and `pad_out_o` = bit n of the address latch. Its direction and open-drain bits are ignored.
- R7: The address latch loads the `ad_i` value sampled in the last clock where `ale_i` was high. It loads at the first clock edge where `ale_i` is seen low after being high, and it holds its value at all other times.
- R8: A read happens when `bus_cs_i` and `bus_re_i` are both high at a clock edge. `bus_rdata_o` is updated at that edge with: offset 0 the direction bits, 1 the output-latch bits, 2 the address-mode bits, 3 the synchronized pin levels. Otherwise `bus_rdata_o` holds its value.
- R9: A change on `pad_i` reaches the pin-level register through two flops. A read that samples one clock after the change returns the old level, and a read that samples three clocks after the change returns the new level.
- R10: The output-latch register reads back the last value written to it, whatever the pin direction, address mode or pin level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_cs_i | input | 1 | Register chip select |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| ale_i | input | 1 | Address latch enable from the processor |
| ad_i | input | 8 | Shared low address/data bus |
| pad_i | input | 8 | Observed pin levels |
| pad_oe_o | output | 8 | Per-pin output enable |
| pad_out_o | output | 8 | Per-pin output value |

## Verification
The assertions check these properties on every cycle:
- The pin drivers keep to their three modes: input pins are released, open-drain pins never drive high, and address-mode pins are always driven.
- The address latch holds between falling edges of the strobe.
- Registers and read data hold when no strobe is qualified by chip select.

Only the bench scenarios can show the rest:
- The latch picks the last address seen while the strobe was high.
- The two-clock latency of pin readback.
- The pull-up seen through an open-drain pin.
- Every combination of direction, data, open-drain and mode on each bit.

The bench does this by comparing a behavioural model against the outputs on every clock.

// File: rtl/cfg_io_pkg.sv
package cfg_io_pkg;
  // offset map: 3 writes the open-drain select and reads the pin levels
  typedef enum logic [1:0] {
    REG_DIR    = 2'd0,
    REG_DATA   = 2'd1,
    REG_MODE   = 2'd2,
    REG_PIN_OD = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    DRV_INPUT = 2'd0,
    DRV_PUSH  = 2'd1,
    DRV_OPEN  = 2'd2,
    DRV_ADDR  = 2'd3
  } drv_kind_e;
endpackage

// File: rtl/cfg_io_regs.sv
module cfg_io_regs
  import cfg_io_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [1:0]       addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] pin_sync_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] data_o,
  output logic [WIDTH-1:0] mode_o,
  output logic [WIDTH-1:0] od_o
);
  logic             wr_en, rd_en;
  reg_sel_e         sel;
  logic [WIDTH-1:0] rd_mux;

  assign wr_en = cs_i & we_i;
  assign rd_en = cs_i & re_i;
  assign sel   = reg_sel_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o  <= '0;
      data_o <= '0;
      mode_o <= '0;
      od_o   <= '0;
    end else if (wr_en) begin
      unique case (sel)
        REG_DIR:    dir_o  <= wdata_i;
        REG_DATA:   data_o <= wdata_i;
        REG_MODE:   mode_o <= wdata_i;
        REG_PIN_OD: od_o   <= wdata_i;
        default:    ;
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      REG_DIR:    rd_mux = dir_o;
      REG_DATA:   rd_mux = data_o;
      REG_MODE:   rd_mux = mode_o;
      REG_PIN_OD: rd_mux = pin_sync_i;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (rd_en) rdata_o <= rd_mux;
  end

  // R2: unselected strobes leave configuration untouched
  p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && we_i) |=> ($stable(dir_o) && $stable(data_o) && $stable(mode_o) && $stable(od_o)));

  // R8: read data holds without a qualified read
  p_rdata_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && re_i) |=> $stable(rdata_o));
endmodule

// File: rtl/cfg_io_addr_latch.sv
module cfg_io_addr_latch #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ale_i,
  input  logic [WIDTH-1:0] ad_i,
  output logic [WIDTH-1:0] addr_o
);
  logic             ale_q;
  logic [WIDTH-1:0] ad_q;
  logic             ale_fall;

  assign ale_fall = ale_q & ~ale_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ale_q  <= 1'b0;
      ad_q   <= '0;
      addr_o <= '0;
    end else begin
      ale_q <= ale_i;
      ad_q  <= ad_i;
      // ad_q holds the bus value from the last cycle the strobe was high
      if (ale_fall) addr_o <= ad_q;
    end
  end

  // R7: latch only moves on a trailing strobe edge
  p_latch_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ale_q && !ale_i) |=> $stable(addr_o));
endmodule

// File: rtl/cfg_io_sync.sv
module cfg_io_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_io_pin_drv.sv
module cfg_io_pin_drv
  import cfg_io_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] mode_i,
  input  logic [WIDTH-1:0] od_i,
  input  logic [WIDTH-1:0] addr_i,
  output logic [WIDTH-1:0] oe_o,
  output logic [WIDTH-1:0] out_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    drv_kind_e kind;

    always_comb begin
      if (mode_i[i])     kind = DRV_ADDR;
      else if (!dir_i[i]) kind = DRV_INPUT;
      else if (od_i[i])  kind = DRV_OPEN;
      else               kind = DRV_PUSH;
    end

    always_comb begin
      unique case (kind)
        DRV_ADDR: begin oe_o[i] = 1'b1;       out_o[i] = addr_i[i]; end
        DRV_PUSH: begin oe_o[i] = 1'b1;       out_o[i] = data_i[i]; end
        DRV_OPEN: begin oe_o[i] = ~data_i[i]; out_o[i] = 1'b0;      end
        default:  begin oe_o[i] = 1'b0;       out_o[i] = 1'b0;      end
      endcase
    end

    // R3: input pins are released
    p_input_released_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mode_i[i] && !dir_i[i]) |-> !oe_o[i]);
    // R5: open-drain never drives high
    p_od_no_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mode_i[i] && od_i[i]) |-> !(oe_o[i] && out_o[i]));
    // R6: address pins always driven
    p_addr_driven_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_i[i] |-> (oe_o[i] && out_o[i] == addr_i[i]));
  end
endmodule

// File: rtl/cfg_io_port.sv
module cfg_io_port #(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_cs_i,
  input  logic             bus_we_i,
  input  logic             bus_re_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [WIDTH-1:0] bus_wdata_i,
  output logic [WIDTH-1:0] bus_rdata_o,
  input  logic             ale_i,
  input  logic [WIDTH-1:0] ad_i,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] pad_oe_o,
  output logic [WIDTH-1:0] pad_out_o
);
  logic [WIDTH-1:0] dir_q, data_q, mode_q, od_q, addr_q, pin_sync;

  cfg_io_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_i),
    .q_o    (pin_sync)
  );

  cfg_io_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_i       (bus_cs_i),
    .we_i       (bus_we_i),
    .re_i       (bus_re_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .pin_sync_i (pin_sync),
    .rdata_o    (bus_rdata_o),
    .dir_o      (dir_q),
    .data_o     (data_q),
    .mode_o     (mode_q),
    .od_o       (od_q)
  );

  cfg_io_addr_latch #(.WIDTH(WIDTH)) u_alat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ale_i  (ale_i),
    .ad_i   (ad_i),
    .addr_o (addr_q)
  );

  cfg_io_pin_drv #(.WIDTH(WIDTH)) u_drv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dir_i  (dir_q),
    .data_i (data_q),
    .mode_i (mode_q),
    .od_i   (od_q),
    .addr_i (addr_q),
    .oe_o   (pad_oe_o),
    .out_o  (pad_out_o)
  );

  // R1: leaving reset nothing is driven until configured
  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pad_oe_o == '0));
endmodule

// File: tb/tb_cfg_io_port.sv
module tb_cfg_io_port;
  localparam int W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_cs_i = 0, bus_we_i = 0, bus_re_i = 0;
  logic [1:0] bus_addr_i = '0;
  logic [W-1:0] bus_wdata_i = '0;
  logic [W-1:0] bus_rdata_o;
  logic ale_i = 0;
  logic [W-1:0] ad_i = '0;
  logic [W-1:0] pad_i, pad_oe_o, pad_out_o;
  logic [W-1:0] ext_low = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  // external pull-up, plus optional external device pulling low
  for (genvar i = 0; i < W; i++) begin : g_pull
    assign pad_i[i] = (pad_oe_o[i] ? pad_out_o[i] : 1'b1) & ~ext_low[i];
  end

  cfg_io_port dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_cs_i(bus_cs_i), .bus_we_i(bus_we_i),
    .bus_re_i(bus_re_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .ale_i(ale_i), .ad_i(ad_i), .pad_i(pad_i),
    .pad_oe_o(pad_oe_o), .pad_out_o(pad_out_o)
  );

  // behavioural reference
  logic [W-1:0] m_dir, m_dat, m_mode, m_od, m_latch, m_ad_q, m_s1, m_s2, m_rdata;
  logic m_ale_q;

  function automatic logic [1:0] exp_pin(int i); // {oe,out}
    if (m_mode[i]) return {1'b1, m_latch[i]};
    if (!m_dir[i]) return 2'b00;
    if (m_od[i]) return {~m_dat[i], 1'b0};
    return {1'b1, m_dat[i]};
  endfunction

  function automatic logic [W-1:0] exp_pad();
    logic [W-1:0] p;
    for (int i = 0; i < W; i++) begin
      logic [1:0] e;
      e = exp_pin(i);
      p[i] = (e[1] ? e[0] : 1'b1) & ~ext_low[i];
    end
    return p;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_dir <= '0; m_dat <= '0; m_mode <= '0; m_od <= '0; m_latch <= '0;
      m_ad_q <= '0; m_s1 <= '0; m_s2 <= '0; m_rdata <= '0; m_ale_q <= 0;
    end else begin
      if (bus_cs_i && bus_re_i)
        case (bus_addr_i)
          2'd0: m_rdata <= m_dir;
          2'd1: m_rdata <= m_dat;
          2'd2: m_rdata <= m_mode;
          default: m_rdata <= m_s2;
        endcase
      if (bus_cs_i && bus_we_i)
        case (bus_addr_i)
          2'd0: m_dir <= bus_wdata_i;
          2'd1: m_dat <= bus_wdata_i;
          2'd2: m_mode <= bus_wdata_i;
          default: m_od <= bus_wdata_i;
        endcase
      if (m_ale_q && !ale_i) m_latch <= m_ad_q;
      m_ale_q <= ale_i;
      m_ad_q <= ad_i;
      m_s1 <= exp_pad();
      m_s2 <= m_s1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      for (int i = 0; i < W; i++) begin
        logic [1:0] e;
        string tag;
        e = exp_pin(i);
        if (m_mode[i]) tag = "R6";
        else if (!m_dir[i]) tag = "R3";
        else if (m_od[i]) tag = "R5";
        else tag = "R4";
        check({pad_oe_o[i], pad_out_o[i]} == e, $sformatf("%s pin %0d oe/out", tag, i),
              {6'd0, pad_oe_o[i], pad_out_o[i]}, {6'd0, e});
      end
      check(bus_rdata_o == m_rdata, "R8 rdata", bus_rdata_o, m_rdata);
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d, input bit sel = 1);
    @(negedge clk_i);
    bus_cs_i = sel; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_cs_i = 0; bus_we_i = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [W-1:0] v);
    @(negedge clk_i);
    bus_cs_i = 1; bus_re_i = 1; bus_addr_i = a;
    @(negedge clk_i);
    bus_cs_i = 0; bus_re_i = 0;
    v = bus_rdata_o;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    check(pad_oe_o == 0, "R1 oe after reset", pad_oe_o, 8'h00);
    check(bus_rdata_o == 0, "R1 rdata after reset", bus_rdata_o, 8'h00);
    bus_read(2'd0, v); check(v == 8'h00, "R1 dir reset", v, 8'h00);
    bus_read(2'd2, v); check(v == 8'h00, "R1 mode reset", v, 8'h00);
    bus_read(2'd3, v); check(v == 8'hFF, "R1 pins pulled up", v, 8'hFF);

    // R2 write without chip select ignored
    bus_write(2'd0, 8'hFF, 0);
    bus_read(2'd0, v); check(v == 8'h00, "R2 unselected write", v, 8'h00);
    check(pad_oe_o == 8'h00, "R2 no pins driven", pad_oe_o, 8'h00);

    // mixed GPIO: low nibble input, bits 4-5 push-pull, bits 6-7 open-drain
    bus_write(2'd0, 8'hF0);
    bus_write(2'd1, 8'hA5);
    bus_write(2'd3, 8'hC0);
    bus_read(2'd0, v); check(v == 8'hF0, "R2 dir readback", v, 8'hF0);
    bus_read(2'd1, v); check(v == 8'hA5, "R10 data readback", v, 8'hA5);
    repeat (2) @(negedge clk_i);
    bus_read(2'd3, v); check(v == 8'hAF, "R5 pins with open-drain", v, 8'hAF);
    check(pad_oe_o == 8'h70, "R4 R5 oe pattern", pad_oe_o, 8'h70);

    // R9 synchronizer latency
    @(negedge clk_i); ext_low = 8'h01;
    bus_read(2'd3, v); check(v == 8'hAF, "R9 old level one clock after", v, 8'hAF);
    bus_read(2'd3, v); check(v == 8'hAE, "R9 new level after sync", v, 8'hAE);
    ext_low = 8'h00;

    // R7 address latch
    @(negedge clk_i); ale_i = 1; ad_i = 8'h3C;
    @(negedge clk_i); ale_i = 0; ad_i = 8'h99;
    repeat (3) @(negedge clk_i); ad_i = 8'h11;
    bus_write(2'd2, 8'h0F);
    @(negedge clk_i);
    check(pad_oe_o[3:0] == 4'hF, "R6 addr pins driven", {4'h0, pad_oe_o[3:0]}, 8'h0F);
    check(pad_out_o[3:0] == 4'hC, "R7 latched low addr", {4'h0, pad_out_o[3:0]}, 8'h0C);
    bus_read(2'd2, v); check(v == 8'h0F, "R8 mode readback", v, 8'h0F);

    // multi-cycle strobe with changing bus: last high value kept
    bus_write(2'd2, 8'hFF);
    @(negedge clk_i); ale_i = 1; ad_i = 8'h12;
    @(negedge clk_i); ad_i = 8'h34;
    @(negedge clk_i); ad_i = 8'h56;
    @(negedge clk_i); ale_i = 0; ad_i = 8'hEE;
    repeat (2) @(negedge clk_i);
    check(pad_out_o == 8'h56, "R7 last address while strobe high", pad_out_o, 8'h56);
    ad_i = 8'h00;
    repeat (3) @(negedge clk_i);
    check(pad_out_o == 8'h56, "R7 latch holds", pad_out_o, 8'h56);

    // R10 data written while in address mode
    bus_write(2'd1, 8'h5A);
    bus_read(2'd1, v); check(v == 8'h5A, "R10 data in addr mode", v, 8'h5A);
    check(pad_out_o == 8'h56, "R6 data ignored in addr mode", pad_out_o, 8'h56);

    // every combination per bit, checked each clock by the model
    for (int k = 0; k < 16; k++) begin
      logic [W-1:0] d, t, o, m;
      for (int i = 0; i < W; i++) begin
        int c;
        c = (k + i) % 16;
        d[i] = c[0]; t[i] = c[1]; o[i] = c[2]; m[i] = c[3];
      end
      bus_write(2'd0, d);
      bus_write(2'd1, t);
      bus_write(2'd3, o);
      bus_write(2'd2, m);
      ext_low = k[0] ? 8'h81 : 8'h00;
      repeat (3) @(negedge clk_i);
      bus_read(2'd3, v);
    end

    repeat (2) @(negedge clk_i);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule